// File: doc/BRIEF.md
# Event record log queue

This block holds one bounded, ordered log of fixed-size event records for a memory-expansion device. Hardware event sources insert records. The block stamps each record with a nonzero 16-bit handle and the current 64-bit timestamp, then appends it at the tail. The host side reads records from the head without removing them (get). It removes them by sending back the handles it has seen (clear), or it empties the whole log (discard). A status bit shows that the log is not empty. A one-cycle interrupt request fires when the log goes from empty to one record. When inserts are refused because the log is full, the block counts them and keeps the timestamps of the first and the latest refusal.

Only one operation runs at a time. A request is taken on `op_valid_i` while `busy_o` is low. Every operation ends with a one-cycle `done_o` pulse carrying a result code. Get sends its records one per cycle on a valid/ready output stream. Clear takes its handles on a valid/ready input stream and holds them in a small buffer. It then checks all of them before it removes anything.

The controller has four states. IDLE accepts requests. Insert, discard and every rejected request finish in IDLE within the accepting cycle. GET streams records. CLR_LOAD collects handles. CLR_CHECK validates the handles and removes records. The transitions are:
- IDLE to GET, on an accepted get.
- GET to IDLE, once the last record is sent.
- IDLE to CLR_LOAD, on an accepted clear whose count fits the buffer.
- CLR_LOAD to CLR_CHECK, once all handles are held.
- CLR_CHECK to IDLE, after one cycle.

Top module: `evlog_queue`

## Requirements
- R1: The log holds at most 8 records. An insert into a full log stores nothing and finishes with result code 2 (refused). Result codes are 0 = OK and 1 = invalid input.
- R2: Each refused insert increments the overflow counter and records the current timestamp as the last overflow time. If the counter was zero before the refusal, it also records that timestamp as the first overflow time.
- R3: Handles start at 1 after reset and increase by one per accepted insert. The value 0 is skipped on wrap, so after 65535 comes 1.
- R4: An accepted record carries the `ts_i` value of its accepting cycle. The status bit is set by an accepted insert and is cleared whenever the log becomes empty.
- R5: The interrupt request is high for one cycle, and only after an accepted insert that takes the record count from 0 to 1.
- R6: A get streams min(request count, records held) records in order from the head and removes none. A stalled record holds valid and its contents until it is taken.
- R7: When a get finishes, `got_count_o` gives the number of records sent. `more_o` is high when the log is not empty. `ovf_flag_o` is high when the overflow counter is nonzero, and the counter and both overflow timestamps are reported.
- R8: A clear of n handles compares handle i with the record at position i from the head, for i below min(n, records held). If any compared handle is 0 or differs, the result is 1 and nothing is removed.
- R9: A clear that passes the check removes min(n, records held) records from the head. Any removal sets the overflow counter and both overflow timestamps to zero.
- R10: Discard empties the log, clears the status bit and zeroes the overflow statistics. The handle counter is kept.
- R11: Operation codes are 0 insert, 1 get, 2 clear, 3 discard. A log selector of 5 or above, or a clear count above 8, finishes at once with result 1. It changes no state and takes no handles.
- R12: While `busy_o` is high no request is accepted. After a multi-cycle operation, `done_o` is raised together with the return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_i | input | 64 | Current timestamp |
| op_valid_i | input | 1 | Request strobe |
| op_code_i | input | 2 | Operation: 0 insert, 1 get, 2 clear, 3 discard |
| op_sel_i | input | 3 | Log selector; values below 5 are valid |
| op_count_i | input | 4 | Get: max records; clear: number of handles |
| ins_data_i | input | 32 | Record payload for insert |
| busy_o | output | 1 | A get or clear is in progress |
| hnd_valid_i | input | 1 | Clear handle stream valid |
| hnd_data_i | input | 16 | Clear handle |
| hnd_ready_o | output | 1 | Clear handle stream ready |
| rec_valid_o | output | 1 | Get record stream valid |
| rec_ready_i | input | 1 | Get record stream ready |
| rec_data_o | output | 32 | Record payload |
| rec_handle_o | output | 16 | Record handle |
| rec_ts_o | output | 64 | Record timestamp |
| done_o | output | 1 | Operation finished (one cycle) |
| result_o | output | 2 | Result code: 0 OK, 1 invalid, 2 refused |
| got_count_o | output | 4 | Records sent by the last get |
| more_o | output | 1 | Log not empty at end of last get |
| ovf_flag_o | output | 1 | Overflow counter nonzero at end of last get |
| ovf_count_o | output | 16 | Overflow counter |
| ovf_first_o | output | 64 | First overflow timestamp |
| ovf_last_o | output | 64 | Latest overflow timestamp |
| status_o | output | 1 | Log not empty |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
On every cycle, the assertions check the following:
- No write reaches a full buffer, and no removal exceeds the records held.
- The handle register never holds zero.
- The first overflow time is latched only on the first refusal.
- The status bit agrees with the record count.
- The interrupt pulse coincides with a count of one.
- A rejected clear leaves the count unchanged.
- A stalled record stays put.

The following can only be shown by the bench scenarios, which replay every operation against a queue model:
- Get returns the right records in the right order.
- Partially valid handle lists are rejected as a whole.
- Handles roll past 65535 to 1.
- Refusal statistics survive until a removal.
- Requests made while busy are ignored.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
    typedef enum logic [1:0] {
        OP_INSERT  = 2'd0,
        OP_GET     = 2'd1,
        OP_CLEAR   = 2'd2,
        OP_DISCARD = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_INVALID = 2'd1,
        RES_FULL    = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GET,
        ST_CLR_LOAD,
        ST_CLR_CHECK
    } st_e;
endpackage

// File: rtl/evlog_store.sv
// Circular record buffer; DEPTH must be a power of two.
module evlog_store #(
    parameter int DEPTH = 8,
    parameter int W     = 112,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  push_rec_i,
    input  logic [CW-1:0] pop_n_i,
    input  logic          flush_i,
    output logic [CW-1:0] count_o,
    output logic [W-1:0]  peek_o [DEPTH]
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else if (flush_i) begin
            head_q  <= tail_q;
            count_q <= '0;
        end else begin
            if (push_i) tail_q <= tail_q + PW'(1);
            head_q  <= head_q + PW'(pop_n_i);
            count_q <= count_q + CW'(push_i) - pop_n_i;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !flush_i) mem[tail_q] <= push_rec_i;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_peek
        assign peek_o[g] = mem[head_q + PW'(g)];
    end

    assign count_o = count_q;

    a_r1_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> count_q < CW'(DEPTH));
    a_r9_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pop_n_i <= count_q);
endmodule

// File: rtl/evlog_handle_gen.sv
module evlog_handle_gen #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    output logic [HW-1:0] handle_o
);
    logic [HW-1:0] h_q;
    logic [HW-1:0] h_nxt;

    assign h_nxt = h_q + HW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)     h_q <= HW'(1);
        else if (adv_i) h_q <= (h_nxt == '0) ? HW'(1) : h_nxt;
    end

    assign handle_o = h_q;

    a_r3_handle_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        handle_o != '0);
    a_r3_handle_held: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(handle_o));
endmodule

// File: rtl/evlog_ovf.sv
module evlog_ovf #(
    parameter int TSW = 64,
    parameter int OCW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit_i,
    input  logic           clr_i,
    input  logic [TSW-1:0] ts_i,
    output logic [OCW-1:0] cnt_o,
    output logic [TSW-1:0] first_o,
    output logic [TSW-1:0] last_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o   <= '0;
            first_o <= '0;
            last_o  <= '0;
        end else if (hit_i) begin
            if (cnt_o == '0) first_o <= ts_i;
            cnt_o  <= cnt_o + OCW'(1);
            last_o <= ts_i;
        end
    end

    a_r2_first_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !clr_i && cnt_o == '0) |=> first_o == $past(ts_i));
    a_r2_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !clr_i && cnt_o != '0) |=> $stable(first_o));
endmodule

// File: rtl/evlog_queue.sv
module evlog_queue
    import evlog_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int DATA_W   = 32,
    parameter int HANDLE_W = 16,
    parameter int TS_W     = 64,
    parameter int OVF_W    = 16,
    parameter int NUM_LOGS = 5,
    parameter int SEL_W    = 3,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int PW      = $clog2(DEPTH),
    localparam int REC_W   = DATA_W + HANDLE_W + TS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TS_W-1:0]     ts_i,
    input  logic                op_valid_i,
    input  logic [1:0]          op_code_i,
    input  logic [SEL_W-1:0]    op_sel_i,
    input  logic [CW-1:0]       op_count_i,
    input  logic [DATA_W-1:0]   ins_data_i,
    output logic                busy_o,
    input  logic                hnd_valid_i,
    input  logic [HANDLE_W-1:0] hnd_data_i,
    output logic                hnd_ready_o,
    output logic                rec_valid_o,
    input  logic                rec_ready_i,
    output logic [DATA_W-1:0]   rec_data_o,
    output logic [HANDLE_W-1:0] rec_handle_o,
    output logic [TS_W-1:0]     rec_ts_o,
    output logic                done_o,
    output logic [1:0]          result_o,
    output logic [CW-1:0]       got_count_o,
    output logic                more_o,
    output logic                ovf_flag_o,
    output logic [OVF_W-1:0]    ovf_count_o,
    output logic [TS_W-1:0]     ovf_first_o,
    output logic [TS_W-1:0]     ovf_last_o,
    output logic                status_o,
    output logic                irq_o
);
    st_e st_q, st_d;

    logic [CW-1:0]       cnt;
    logic [REC_W-1:0]    peek [DEPTH];
    logic [HANDLE_W-1:0] cur_handle;
    logic [CW-1:0]       sent_q, lim_q, hcnt_q, nreq_q, clr_k, pop_n;
    logic [HANDLE_W-1:0] hbuf [DEPTH];
    logic [DEPTH-1:0]    bad_vec;
    logic                accept, sel_ok, full, push, ovf_hit, flush, clr_bad, hnd_take;
    op_e                 op;

    assign op       = op_e'(op_code_i);
    assign accept   = op_valid_i && (st_q == ST_IDLE);
    assign sel_ok   = {1'b0, op_sel_i} < (SEL_W + 1)'(NUM_LOGS);
    assign full     = (cnt == CW'(DEPTH));
    assign push     = accept && sel_ok && (op == OP_INSERT) && !full;
    assign ovf_hit  = accept && sel_ok && (op == OP_INSERT) && full;
    assign flush    = accept && sel_ok && (op == OP_DISCARD);
    assign clr_k    = (nreq_q < cnt) ? nreq_q : cnt;

    // Handle check: only positions that hold a record are compared.
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        assign bad_vec[g] = (CW'(g) < clr_k) &&
                            ((hbuf[g] == '0) || (peek[g][TS_W +: HANDLE_W] != hbuf[g]));
    end
    assign clr_bad = |bad_vec;
    assign pop_n   = (st_q == ST_CLR_CHECK && !clr_bad) ? clr_k : '0;

    assign busy_o       = (st_q != ST_IDLE);
    assign rec_valid_o  = (st_q == ST_GET) && (sent_q < lim_q);
    assign rec_data_o   = peek[sent_q[PW-1:0]][REC_W-1 -: DATA_W];
    assign rec_handle_o = peek[sent_q[PW-1:0]][TS_W +: HANDLE_W];
    assign rec_ts_o     = peek[sent_q[PW-1:0]][TS_W-1:0];
    assign hnd_ready_o  = (st_q == ST_CLR_LOAD) && (hcnt_q < nreq_q);
    assign hnd_take     = hnd_ready_o && hnd_valid_i;

    evlog_store #(.DEPTH(DEPTH), .W(REC_W)) i_store (
        .clk(clk), .rst_n(rst_n), .push_i(push),
        .push_rec_i({ins_data_i, cur_handle, ts_i}),
        .pop_n_i(pop_n), .flush_i(flush), .count_o(cnt), .peek_o(peek)
    );

    evlog_handle_gen #(.HW(HANDLE_W)) i_hgen (
        .clk(clk), .rst_n(rst_n), .adv_i(push), .handle_o(cur_handle)
    );

    evlog_ovf #(.TSW(TS_W), .OCW(OVF_W)) i_ovf (
        .clk(clk), .rst_n(rst_n), .hit_i(ovf_hit), .clr_i(flush || (pop_n != '0)),
        .ts_i(ts_i), .cnt_o(ovf_count_o), .first_o(ovf_first_o), .last_o(ovf_last_o)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept && sel_ok) begin
                    if (op == OP_GET) st_d = ST_GET;
                    else if (op == OP_CLEAR && op_count_i <= CW'(DEPTH)) st_d = ST_CLR_LOAD;
                end
            end
            ST_GET:       if (sent_q == lim_q) st_d = ST_IDLE;
            ST_CLR_LOAD:  if (hcnt_q == nreq_q) st_d = ST_CLR_CHECK;
            ST_CLR_CHECK: st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Outputs and operation registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            result_o    <= RES_OK;
            got_count_o <= '0;
            more_o      <= 1'b0;
            ovf_flag_o  <= 1'b0;
            status_o    <= 1'b0;
            irq_o       <= 1'b0;
            sent_q      <= '0;
            lim_q       <= '0;
            hcnt_q      <= '0;
            nreq_q      <= '0;
        end else begin
            done_o <= 1'b0;
            irq_o  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept && !sel_ok) begin
                        done_o   <= 1'b1;
                        result_o <= RES_INVALID;
                    end else if (accept) begin
                        unique case (op)
                            OP_INSERT: begin
                                done_o   <= 1'b1;
                                result_o <= full ? RES_FULL : RES_OK;
                                if (!full) begin
                                    status_o <= 1'b1;
                                    irq_o    <= (cnt == '0);
                                end
                            end
                            OP_GET: begin
                                sent_q <= '0;
                                lim_q  <= (op_count_i < cnt) ? op_count_i : cnt;
                            end
                            OP_CLEAR: begin
                                if (op_count_i > CW'(DEPTH)) begin
                                    done_o   <= 1'b1;
                                    result_o <= RES_INVALID;
                                end
                                hcnt_q <= '0;
                                nreq_q <= op_count_i;
                            end
                            OP_DISCARD: begin
                                done_o   <= 1'b1;
                                result_o <= RES_OK;
                                status_o <= 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_GET: begin
                    if (rec_valid_o && rec_ready_i) sent_q <= sent_q + CW'(1);
                    if (sent_q == lim_q) begin
                        done_o      <= 1'b1;
                        result_o    <= RES_OK;
                        got_count_o <= sent_q;
                        more_o      <= (cnt != '0);
                        ovf_flag_o  <= (ovf_count_o != '0);
                    end
                end
                ST_CLR_LOAD: begin
                    if (hnd_take) hcnt_q <= hcnt_q + CW'(1);
                end
                ST_CLR_CHECK: begin
                    done_o   <= 1'b1;
                    result_o <= clr_bad ? RES_INVALID : RES_OK;
                    if (!clr_bad && clr_k == cnt) status_o <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (hnd_take) hbuf[hcnt_q[PW-1:0]] <= hnd_data_i;
    end

    a_r4_status_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        status_o == (cnt != '0));
    a_r5_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cnt == CW'(1));
    a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    a_r8_invalid_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == RES_INVALID) |-> cnt == $past(cnt));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && !rec_ready_i) |=> rec_valid_o && $stable(rec_handle_o) && $stable(rec_data_o));
    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(st_q) != ST_IDLE) |-> st_q == ST_IDLE);
endmodule

// File: tb/test_evlog_queue.sv
`timescale 1ns/1ps
module test_evlog_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ts_i = '0;
    logic        op_valid_i = 1'b0;
    logic [1:0]  op_code_i = '0;
    logic [2:0]  op_sel_i = '0;
    logic [3:0]  op_count_i = '0;
    logic [31:0] ins_data_i = '0;
    logic        busy_o;
    logic        hnd_valid_i = 1'b0;
    logic [15:0] hnd_data_i = '0;
    logic        hnd_ready_o;
    logic        rec_valid_o;
    logic        rec_ready_i = 1'b0;
    logic [31:0] rec_data_o;
    logic [15:0] rec_handle_o;
    logic [63:0] rec_ts_o;
    logic        done_o;
    logic [1:0]  result_o;
    logic [3:0]  got_count_o;
    logic        more_o, ovf_flag_o;
    logic [15:0] ovf_count_o;
    logic [63:0] ovf_first_o, ovf_last_o;
    logic        status_o, irq_o;

    evlog_queue i_evlog_queue (
        .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .op_valid_i(op_valid_i),
        .op_code_i(op_code_i), .op_sel_i(op_sel_i), .op_count_i(op_count_i),
        .ins_data_i(ins_data_i), .busy_o(busy_o), .hnd_valid_i(hnd_valid_i),
        .hnd_data_i(hnd_data_i), .hnd_ready_o(hnd_ready_o), .rec_valid_o(rec_valid_o),
        .rec_ready_i(rec_ready_i), .rec_data_o(rec_data_o), .rec_handle_o(rec_handle_o),
        .rec_ts_o(rec_ts_o), .done_o(done_o), .result_o(result_o),
        .got_count_o(got_count_o), .more_o(more_o), .ovf_flag_o(ovf_flag_o),
        .ovf_count_o(ovf_count_o), .ovf_first_o(ovf_first_o), .ovf_last_o(ovf_last_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model
    typedef struct {
        logic [31:0] d;
        logic [15:0] h;
        logic [63:0] t;
    } rec_t;
    rec_t        q[$];
    int          next_h = 1;
    int          ovc = 0;
    logic [63:0] ov_first = '0, ov_last = '0;
    bit          m_status = 1'b0;
    bit          irq_pend = 1'b0;
    bit          started = 1'b0;
    logic [63:0] tsv = 64'd100;
    logic [15:0] hv [16];
    int          n_cmp = 0, n_bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Every-cycle comparison of status and interrupt
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (started) begin
                chk("R4 status bit", status_o, m_status);
                chk("R5 irq", irq_o, irq_pend);
                irq_pend = 1'b0;
            end
        end
    end

    task automatic issue();
        op_valid_i = 1'b1;
        @(posedge clk);
        #1;
        op_valid_i = 1'b0;
    endtask

    task automatic ins(input int sel, input logic [31:0] d);
        int res;
        rec_t r;
        ts_i = tsv; op_code_i = 2'd0; op_sel_i = sel[2:0]; ins_data_i = d;
        issue();
        if (sel >= 5) res = 1;
        else if (q.size() >= 8) begin
            res = 2;
            if (ovc == 0) ov_first = tsv;
            ovc++;
            ov_last = tsv;
        end else begin
            res = 0;
            r.d = d; r.h = next_h[15:0]; r.t = tsv;
            q.push_back(r);
            next_h++;
            if (next_h == 65536) next_h = 1;
            m_status = 1'b1;
            if (q.size() == 1) irq_pend = 1'b1;
        end
        chk("R1 insert done", done_o, 1);
        chk("R1/R11 insert result", result_o, res);
        tsv = tsv + 64'd7;
    endtask

    task automatic disc(input int sel);
        op_code_i = 2'd3; op_sel_i = sel[2:0];
        issue();
        chk("R10 discard done", done_o, 1);
        chk("R10/R11 discard result", result_o, (sel >= 5) ? 1 : 0);
        if (sel < 5) begin
            q.delete();
            ovc = 0; ov_first = '0; ov_last = '0;
            m_status = 1'b0;
        end
    endtask

    task automatic do_get(input int sel, input int maxn, input bit poke);
        int lim, idx;
        bit v, r;
        op_code_i = 2'd1; op_sel_i = sel[2:0]; op_count_i = maxn[3:0];
        issue();
        if (sel >= 5) begin
            chk("R11 get bad selector done", done_o, 1);
            chk("R11 get bad selector result", result_o, 1);
            return;
        end
        lim = (maxn < q.size()) ? maxn : q.size();
        idx = 0;
        for (int c = 0; c < 300; c++) begin
            if (done_o) break;
            if (poke && c < 3) begin
                chk("R12 busy during get", busy_o, 1);
                op_valid_i = 1'b1; op_code_i = 2'd0; op_sel_i = 3'd0; ts_i = 64'hDEAD;
            end else begin
                op_valid_i = 1'b0;
            end
            v = rec_valid_o;
            if (v) begin
                if (idx < lim) begin
                    chk("R6 record data", rec_data_o, q[idx].d);
                    chk("R6/R3 record handle", rec_handle_o, q[idx].h);
                    chk("R4 record timestamp", rec_ts_o, q[idx].t);
                end else begin
                    chk("R6 record beyond limit", 1, 0);
                end
            end
            r = poke ? (c >= 3) : ((c % 3) != 1);
            rec_ready_i = r;
            @(posedge clk);
            #1;
            if (v && r) idx++;
        end
        op_valid_i = 1'b0;
        rec_ready_i = 1'b0;
        chk("R7 get done", done_o, 1);
        chk("R6 records streamed", idx, lim);
        chk("R7 got count", got_count_o, lim);
        chk("R7 more flag", more_o, q.size() != 0);
        chk("R7 overflow flag", ovf_flag_o, ovc != 0);
        chk("R7/R2 overflow count", ovf_count_o, ovc);
        chk("R7/R2 first overflow ts", ovf_first_o, ov_first);
        chk("R7/R2 last overflow ts", ovf_last_o, ov_last);
    endtask

    task automatic clr(input int sel, input int n);
        int i, k, res;
        bit bad, rdy;
        op_code_i = 2'd2; op_sel_i = sel[2:0]; op_count_i = n[3:0];
        issue();
        if (sel >= 5 || n > 8) begin
            chk("R11 clear rejected done", done_o, 1);
            chk("R11 clear rejected result", result_o, 1);
            chk("R11 no handle taken", hnd_ready_o, 0);
            return;
        end
        i = 0;
        for (int c = 0; c < 300; c++) begin
            if (done_o) break;
            hnd_valid_i = (i < n) && (c % 4 != 2);
            hnd_data_i = hv[i];
            rdy = hnd_ready_o;
            @(posedge clk);
            #1;
            if (hnd_valid_i && rdy) i++;
        end
        hnd_valid_i = 1'b0;
        k = (n < q.size()) ? n : q.size();
        bad = 1'b0;
        for (int j = 0; j < k; j++) if (hv[j] == 16'd0 || hv[j] != q[j].h) bad = 1'b1;
        res = bad ? 1 : 0;
        if (!bad) begin
            for (int j = 0; j < k; j++) void'(q.pop_front());
            if (k > 0) begin ovc = 0; ov_first = '0; ov_last = '0; end
            if (q.size() == 0) m_status = 1'b0;
        end
        chk("R8 clear done", done_o, 1);
        chk("R8/R9 clear result", result_o, res);
        chk("R8 handles consumed", i, n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        started = 1'b1;
        chk("R12 reset busy", busy_o, 0);
        chk("R4 reset status", status_o, 0);
        chk("R12 reset done", done_o, 0);
        chk("R6 reset rec valid", rec_valid_o, 0);
        chk("R5 reset irq", irq_o, 0);

        // R3 R4 R5: first records
        for (int j = 0; j < 3; j++) ins(0, 32'hA000_0000 + j);
        do_get(0, 8, 1'b0);
        do_get(1, 2, 1'b0);
        do_get(0, 0, 1'b0);
        // R12: requests while busy are ignored
        do_get(0, 3, 1'b1);
        do_get(0, 15, 1'b0);
        // R1 R2: fill and overflow
        for (int j = 3; j < 8; j++) ins(0, 32'hB000_0000 + j);
        ins(0, 32'hBAD0_0001);
        ins(4, 32'hBAD0_0002);
        ins(2, 32'hBAD0_0003);
        do_get(0, 15, 1'b0);
        // R8: mismatch at second position, zero at head
        hv[0] = 16'd1; hv[1] = 16'd5;
        clr(0, 2);
        hv[0] = 16'd0;
        clr(0, 1);
        do_get(0, 8, 1'b0);
        // R9: valid removal of three records, overflow reset
        hv[0] = 16'd1; hv[1] = 16'd2; hv[2] = 16'd3;
        clr(0, 3);
        do_get(0, 8, 1'b0);
        // R11: rejected selectors and clear count
        ins(6, 32'hC0DE_0001);
        do_get(5, 4, 1'b0);
        clr(7, 2);
        clr(0, 12);
        do_get(0, 8, 1'b0);
        // R8 R9: remove all, then clear on empty log checks nothing
        for (int j = 0; j < 5; j++) hv[j] = 16'(4 + j);
        clr(0, 5);
        hv[0] = 16'd0; hv[1] = 16'd0;
        clr(0, 2);
        do_get(0, 8, 1'b0);
        // R5 R10: irq again, discard keeps handle counter
        ins(0, 32'hD000_0001);
        ins(0, 32'hD000_0002);
        ins(0, 32'hD000_0003);
        ins(0, 32'hD000_0004);
        ins(0, 32'hD000_0005);
        ins(0, 32'hD000_0006);
        ins(0, 32'hD000_0007);
        ins(0, 32'hD000_0008);
        ins(0, 32'hD000_0009);
        disc(0);
        do_get(0, 8, 1'b0);
        ins(0, 32'hD000_000A);
        do_get(0, 8, 1'b0);
        // R3: handle wrap skips zero
        while (next_h != 65533) begin
            if (q.size() == 8) disc(0);
            else ins(0, 32'h5000_0000 + next_h);
        end
        disc(0);
        for (int j = 0; j < 4; j++) ins(0, 32'h6000_0000 + j);
        chk("R3 wrapped handle model", q[3].h, 16'd1);
        do_get(0, 4, 1'b0);
        hv[0] = 16'd65533; hv[1] = 16'd65534; hv[2] = 16'd65535; hv[3] = 16'd1;
        clr(0, 4);
        do_get(0, 8, 1'b0);

        repeat (2) @(posedge clk);
        #1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule